// File: doc/BRIEF.md
# Filter Coefficient and Control Register Bank

This block holds the tap coefficients for a pair of 8-tap filters, plus a small set of control words. Software-side logic loads it one 10-bit word at a time through a data port and a 9-bit address port, under a separate write strobe. The strobe has no fixed timing relation to the clock. The block brings the strobe into the clock domain through a synchronizer and detects its edges there. The address is sampled when a falling strobe edge is detected. The data is sampled, and the addressed register is written, when the matching rising edge is detected.

The storage holds 32 coefficient sets of 8 taps each. A 5-bit set select is registered on every clock and picks one whole set. That set is presented as one 80-bit bus, and the same bus feeds the multipliers of both filter channels. The control words appear on a separate bus. This block does not interpret the control bits.

Top module: `ccr_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every coefficient and every control word reads zero on `coef_taps` and `ctrl_words`.
- R2: The write address is sampled on the third rising clock edge after `wr_stb` goes low. Address changes after that edge have no effect on the pending write.
- R3: Data on `wr_data` is sampled, and the addressed register is updated, on the third rising clock edge after `wr_stb` goes high.
- R4: `set_sel` is registered on every rising clock edge. `coef_taps` then shows the set named by that registered value, with tap k at bits [10k+9:10k].
- R5: An address with bit 8 clear selects a coefficient. Bits 7..3 give the set and bits 2..0 give the tap.
- R6: Addresses 0x100 to 0x103 select control word k = address − 0x100, which appears on `ctrl_words` bits [10k+9:10k].
- R7: A write to any address from 0x104 to 0x1FF changes no coefficient and no control word.
- R8: A write to the currently selected set is not visible on `coef_taps` before the edge on which it commits. It is visible right after that edge. If `set_sel` moves to the written set on that same edge, the new set is shown with the new value already in it.
- R9: While `wr_stb` stays steady, no register changes, whatever `wr_addr` and `wr_data` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Asynchronous write strobe; idles high |
| wr_addr | input | 9 | Write address, sampled at the strobe's falling edge |
| wr_data | input | 10 | Write data, sampled at the strobe's rising edge |
| set_sel | input | 5 | Coefficient set select |
| coef_taps | output | 80 | Selected set, 8 taps of 10 bits each |
| ctrl_words | output | 40 | Four control words of 10 bits each |

## Verification
Two events can fall on the same clock edge: the commit of a coefficient write, and a change of the registered set select. The bench provokes this by moving `set_sel` to the target set in the cycle just before the commit edge. It expects the newly chosen set to show the fresh tap value at once. A second case keeps the target set selected throughout and samples the bus one cycle before the commit, where the tap must still hold its old value, and then again after the commit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DW     = 10;             // word width
  localparam int AW     = 9;              // address width
  localparam int SW     = 5;              // set-select width
  localparam int TAPS   = 8;              // taps per set
  localparam int CTRL_N = 4;              // control words
  localparam int SETS   = 1 << SW;
  localparam int TW     = $clog2(TAPS);
  localparam int CW     = $clog2(CTRL_N);

  typedef enum logic [1:0] {K_NONE, K_COEF, K_CTRL} kind_e;

  // Region of an address: coefficient, control or unmapped.
  function automatic kind_e addr_kind(input logic [AW-1:0] a);
    if (!a[AW-1])                          return K_COEF;
    else if (int'(a[AW-2:0]) < CTRL_N)     return K_CTRL;
    else                                   return K_NONE;
  endfunction

  function automatic logic [SW-1:0] addr_set(input logic [AW-1:0] a);
    return a[TW +: SW];
  endfunction

  function automatic logic [TW-1:0] addr_tap(input logic [AW-1:0] a);
    return a[TW-1:0];
  endfunction

  function automatic logic [CW-1:0] addr_ctrl(input logic [AW-1:0] a);
    return a[CW-1:0];
  endfunction
endpackage

// File: rtl/ccr_strobe_sync.sv
module ccr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_async,
  output logic stb_fall,
  output logic stb_rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], stb_async};
  end

  assign stb_fall = chain[STAGES] & ~chain[STAGES-1];
  assign stb_rise = ~chain[STAGES] & chain[STAGES-1];

  // R9: a detected edge lasts exactly one cycle
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> !stb_rise);
  a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> !stb_fall);
endmodule

// File: rtl/ccr_addr_decode.sv
module ccr_addr_decode
  import ccr_pkg::*;
#(
  parameter int A_W = AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [A_W-1:0]  addr_in,
  output kind_e           kind,
  output logic [SW-1:0]   set_idx,
  output logic [TW-1:0]   tap_idx,
  output logic [CW-1:0]   ctrl_idx
);
  logic [A_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= addr_in;
  end

  always_comb begin
    kind     = addr_kind(addr_q);
    set_idx  = addr_set(addr_q);
    tap_idx  = addr_tap(addr_q);
    ctrl_idx = addr_ctrl(addr_q);
  end

  // R2: the latched address moves only on a detected falling strobe
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(addr_q));
endmodule

// File: rtl/ccr_store.sv
module ccr_store
  import ccr_pkg::*;
#(
  parameter int D_W = DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  kind_e                   kind,
  input  logic [SW-1:0]           set_idx,
  input  logic [TW-1:0]           tap_idx,
  input  logic [CW-1:0]           ctrl_idx,
  input  logic [D_W-1:0]          wdata,
  input  logic [SW-1:0]           sel_q,
  output logic [TAPS*D_W-1:0]     taps_out,
  output logic [CTRL_N*D_W-1:0]   ctrl_out
);
  logic [SETS-1:0][TAPS-1:0][D_W-1:0] coef_mem;
  logic [CTRL_N-1:0][D_W-1:0]         ctrl_mem;
  logic coef_we, ctrl_we;

  assign coef_we = commit && (kind == K_COEF);
  assign ctrl_we = commit && (kind == K_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       coef_mem <= '0;
    else if (coef_we) coef_mem[set_idx][tap_idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_mem <= '0;
    else if (ctrl_we) ctrl_mem[ctrl_idx] <= wdata;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign taps_out[t*D_W +: D_W] = coef_mem[sel_q][t];
  end
  for (genvar c = 0; c < CTRL_N; c++) begin : g_ctrl
    assign ctrl_out[c*D_W +: D_W] = ctrl_mem[c];
  end

  // R3/R5: a coefficient commit lands in the decoded slot
  a_r5_coef_lands: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> coef_mem[$past(set_idx)][$past(tap_idx)] == $past(wdata));
  // R6: a control commit lands in the decoded word
  a_r6_ctrl_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_mem[$past(ctrl_idx)] == $past(wdata));
  // R7: unmapped commits touch nothing
  a_r7_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && kind == K_NONE) |=> ($stable(coef_mem) && $stable(ctrl_mem)));
  // R9: no commit, no change
  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(coef_mem) && $stable(ctrl_mem)));
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [SW-1:0]          set_sel,
  output logic [TAPS*DW-1:0]     coef_taps,
  output logic [CTRL_N*DW-1:0]   ctrl_words
);
  logic          stb_fall, stb_rise;
  kind_e         kind;
  logic [SW-1:0] set_idx;
  logic [TW-1:0] tap_idx;
  logic [CW-1:0] ctrl_idx;
  logic [SW-1:0] sel_q;

  ccr_strobe_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_async (wr_stb),
    .stb_fall  (stb_fall),
    .stb_rise  (stb_rise)
  );

  ccr_addr_decode #(.A_W(AW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (stb_fall),
    .addr_in  (wr_addr),
    .kind     (kind),
    .set_idx  (set_idx),
    .tap_idx  (tap_idx),
    .ctrl_idx (ctrl_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= set_sel;
  end

  ccr_store #(.D_W(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (stb_rise),
    .kind     (kind),
    .set_idx  (set_idx),
    .tap_idx  (tap_idx),
    .ctrl_idx (ctrl_idx),
    .wdata    (wr_data),
    .sel_q    (sel_q),
    .taps_out (coef_taps),
    .ctrl_out (ctrl_words)
  );

  // R4: the registered select follows the input one clock later
  a_r4_sel_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sel_q == $past(set_sel));
  // R8: with no commit and a steady select, the tap bus holds
  a_r8_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_rise && set_sel == sel_q) |=> $stable(coef_taps));
endmodule

// File: tb/ccr_regfile_bench.sv
module ccr_regfile_bench;
  import ccr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] set_sel = '0;
  logic [TAPS*DW-1:0]   coef_taps;
  logic [CTRL_N*DW-1:0] ctrl_words;

  always #2 clk = ~clk;

  ccr_regfile u_ccr_regfile (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .set_sel(set_sel), .coef_taps(coef_taps),
    .ctrl_words(ctrl_words)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [DW-1:0] m_coef [SETS][TAPS];
  logic [DW-1:0] m_ctrl [CTRL_N];

  // {address, data}
  localparam int NV = 8;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {9'h000, 10'h155}, {9'h007, 10'h2AA}, {9'h0FF, 10'h3FF},
    {9'h0F8, 10'h001}, {9'h05B, 10'h123}, {9'h100, 10'h0F0},
    {9'h103, 10'h30C}, {9'h12A, 10'h3FF}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [TAPS*DW-1:0] exp_bus(input int s);
    logic [TAPS*DW-1:0] b;
    for (int t = 0; t < TAPS; t++) b[t*DW +: DW] = m_coef[s][t];
    return b;
  endfunction

  function automatic logic [CTRL_N*DW-1:0] exp_ctrl();
    logic [CTRL_N*DW-1:0] b;
    for (int c = 0; c < CTRL_N; c++) b[c*DW +: DW] = m_ctrl[c];
    return b;
  endfunction

  // Bench-side address map: bit 8 clear -> set a[7:3], tap a[2:0];
  // 0x100..0x103 -> control word; the rest ignored.
  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (a < 9'h100)      m_coef[a / 8][a % 8] = d;
    else if (a < 9'h104) m_ctrl[a - 9'h100] = d;
  endtask

  // Address goes with the falling strobe, then is scrambled before the rise (R2).
  task automatic start_write(input logic [AW-1:0] a);
    @(negedge clk); wr_addr = a; wr_stb = 1'b0;
    repeat (4) @(negedge clk);
    wr_addr = ~a;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    start_write(a);
    wr_stb = 1'b1; wr_data = d;
    repeat (4) @(negedge clk);
    model_write(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < TAPS; t++) m_coef[s][t] = '0;
    for (int c = 0; c < CTRL_N; c++) m_ctrl[c] = '0;

    repeat (3) @(negedge clk);
    chk("R1 coef in reset", coef_taps, '0);
    chk("R1 ctrl in reset", ctrl_words, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 coef after reset", coef_taps, '0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = VEC[i][DW +: AW];
      d = VEC[i][DW-1:0];
      set_sel = (a < 9'h100) ? SW'(a / 8) : 5'd0;
      do_write(a, d);
      chk($sformatf("R5 coef bus vec %0d", i), coef_taps, exp_bus(int'(set_sel)));
      chk($sformatf("R6/R7 ctrl vec %0d", i), ctrl_words, exp_ctrl());
    end

    // R4: walk select over written sets
    set_sel = 5'd31; @(negedge clk);
    chk("R4 set 31 bus", coef_taps, exp_bus(31));
    set_sel = 5'd11; @(negedge clk);
    chk("R4 set 11 bus", coef_taps, exp_bus(11));
    set_sel = 5'd0; @(negedge clk);
    chk("R4 set 0 bus", coef_taps, exp_bus(0));

    // R7: unmapped top address leaves everything alone
    do_write(9'h1FF, 10'h2B7);
    chk("R7 set 0 after unmapped", coef_taps, exp_bus(0));
    chk("R7 ctrl after unmapped", ctrl_words, exp_ctrl());

    // R9: steady strobe, busy address and data
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); wr_addr = AW'(k); wr_data = DW'(k * 37);
    end
    repeat (4) @(negedge clk);
    chk("R9 coef unchanged", coef_taps, exp_bus(0));
    chk("R9 ctrl unchanged", ctrl_words, exp_ctrl());

    // R8a: selected set, not visible before the commit edge
    set_sel = 5'd5; @(negedge clk);
    start_write(9'h02A);               // set 5, tap 2
    wr_stb = 1'b1; wr_data = 10'h2C3;
    repeat (2) @(negedge clk);         // two edges seen, commit pending
    chk("R8 before commit", coef_taps, exp_bus(5));
    @(negedge clk);                    // commit edge passed
    model_write(9'h02A, 10'h2C3);
    chk("R8 after commit", coef_taps, exp_bus(5));
    chk("R3 tap value", coef_taps[2*DW +: DW], 10'h2C3);

    // R8b: select moves on the commit edge itself
    set_sel = 5'd0; @(negedge clk);
    start_write(9'h034);               // set 6, tap 4
    wr_stb = 1'b1; wr_data = 10'h1E9;
    repeat (2) @(negedge clk);
    chk("R8 old set before switch", coef_taps, exp_bus(0));
    set_sel = 5'd6;
    @(negedge clk);
    model_write(9'h034, 10'h1E9);
    chk("R8 same-edge switch", coef_taps, exp_bus(6));
    chk("R8 same-edge tap", coef_taps[4*DW +: DW], 10'h1E9);
    repeat (4) @(negedge clk);

    // R2: address scrambled after the fall must not redirect the write
    set_sel = 5'd0; @(negedge clk);
    chk("R2 set 0 untouched by scramble", coef_taps, exp_bus(0));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule